// File: doc/BRIEF.md
# Sparse Word Request Merger for a Shared Memory Channel

This block sits in front of one memory channel and serves several address streams that issue scattered single-word reads and writes. One stream is picked per cycle, in round-robin order. Its word address is split into a burst number and a word offset. A burst is 64 bytes: sixteen 32-bit words.

A small table of pending bursts records which streams wait on which words, and the tag each one supplied. A request for a burst that is already pending in the same direction joins that entry, and no new memory command goes out. A request that finds no pending entry claims a free slot and sends a single burst command. The command carries the slot number, so that returning data can be matched to its entry.

When the memory returns a burst, every waiting word of that entry is answered in one cycle. Each stream receives a word bitmap, a tag per word and the burst data. The slot is then free again. Because many words share a single tracked burst, many requests can be in flight while only a few slots exist. Dense streams that already form whole bursts reach the channel by another route and are not handled here.

Top module: `sparse_coalescer`

## Requirements
- R1: After reset, with no request presented, `req_ready`, `cmd_valid` and `rsp_valid` are all low.
- R2: At most one stream is accepted per cycle. The search for a stream starts one place after the last accepted stream and wraps around; it starts at stream 0 after reset.
- R3: The burst number is the word address with its low 4 bits removed (`addr[AW-1:4]`), and the word offset is `addr[3:0]`. A burst holds 16 words of 32 bits, with word w in `mem_data[w*32 +: 32]`.
- R4: A request that matches no pending entry, while a slot is free, raises `cmd_valid` with its burst number and the index of the free slot on `cmd_id`. It is accepted when `cmd_ready` is high. A request that matches a pending entry is accepted without raising `cmd_valid`.
- R5: Direction is part of the match (`req_wr`: 0 read, 1 write). A write to a burst with a pending read issues its own command with `cmd_wr` = 1.
- R6: A non-matching request stalls while every slot is in use, and the stream order does not move past it. Matching requests are still merged while the table is full. A slot that is retiring in the current cycle does not count as free until the next cycle.
- R7: A request for a word on which the same stream already waits in that entry is held until the entry retires.
- R8: While `cmd_ready` is low, a non-matching request shows `cmd_valid` but is not accepted. Matching requests are accepted regardless of `cmd_ready`.
- R9: One cycle after `mem_valid`, each stream waiting on entry `mem_id` has `rsp_valid` set. Its `rsp_mask` bit w is set for each awaited word w, its tag is at `rsp_tag[(s*16+w)*4 +: 4]`, and `rsp_data` equals the returned burst. Streams with no waiting word have `rsp_valid` low.
- R10: After its data returns, an entry is freed. A later request for the same burst issues a new command.
- R11: A request for a burst whose entry retires in the same cycle is treated as non-matching. It claims a different slot and issues a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NS | Request present, per stream |
| req_ready | output | NS | Request accepted this cycle, per stream |
| req_addr | input | NS*AW | Word address, per stream |
| req_tag | input | NS*TW | Requester tag, per stream |
| req_wr | input | NS | Direction, 1 = write, per stream |
| cmd_valid | output | 1 | Burst command to memory |
| cmd_ready | input | 1 | Memory accepts the command |
| cmd_addr | output | AW-4 | Burst number |
| cmd_wr | output | 1 | Burst direction |
| cmd_id | output | log2(ENTRIES) | Slot that owns the burst |
| mem_valid | input | 1 | Burst completion from memory |
| mem_id | input | log2(ENTRIES) | Slot being completed |
| mem_data | input | WPB*DW | Burst data |
| rsp_valid | output | NS | Response present, per stream |
| rsp_mask | output | NS*WPB | Answered words, per stream |
| rsp_tag | output | NS*WPB*TW | Tag of each answered word |
| rsp_data | output | WPB*DW | Burst data for the responses |

## Verification
The merging path is first swept over every word of one burst from every stream. Every request but the first must join that one entry silently, and the single completion must return a full bitmap with sixteen distinct tags per stream. Sweeping all offsets separates a correct burst/offset split from one that drops or shifts bits. Next, simultaneous misses from all streams show the rotation order and fill the table. Stalls from a full table, from a busy command port and from a repeated word are each then shown apart from the merge of a hit, which still goes through. Last, a read and a write to one burst, and a request that lands in the retirement cycle of its burst, show that both direction and retirement count in the match.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } coal_dir_e;

endpackage

// File: rtl/coal_rr_arb.sv
module coal_rr_arb #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);

  logic [IW-1:0] ptr_q, ptr_d;

  // first requester at or after the pointer, wrapping
  always_comb begin
    gnt_idx = ptr_q;
    for (int k = N - 1; k >= 0; k--) begin
      int c;
      c = int'(ptr_q) + k;
      if (c >= N) c = c - N;
      if (req[c]) gnt_idx = IW'(c);
    end
    gnt = '0;
    if (|req) gnt[gnt_idx] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  AST_GNT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $onehot(gnt)); // R2

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q)); // R6

endmodule

// File: rtl/coal_cache.sv
module coal_cache
  import coal_pkg::*;
#(
  parameter int NS      = 3,
  parameter int BAW     = 12,
  parameter int TW      = 4,
  parameter int WPB     = 16,
  parameter int ENTRIES = 4,
  parameter int OFF_W   = $clog2(WPB),
  parameter int SW      = (NS > 1) ? $clog2(NS) : 1,
  parameter int IDW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BAW-1:0]        lk_baddr,
  input  coal_dir_e             lk_dir,
  input  logic [OFF_W-1:0]      lk_word,
  input  logic [SW-1:0]         lk_stream,
  input  logic [TW-1:0]         lk_tag,
  input  logic                  do_merge,
  input  logic                  do_alloc,
  input  logic                  ret_valid,
  input  logic [IDW-1:0]        ret_id,
  output logic                  hit,
  output logic [IDW-1:0]        hit_idx,
  output logic                  slot_busy,
  output logic                  free_avail,
  output logic [IDW-1:0]        free_idx,
  output logic [WPB*NS-1:0]     ret_wait,
  output logic [WPB*NS*TW-1:0]  ret_tag
);

  localparam int SLOTS = WPB * NS;

  logic                  valid_q [ENTRIES];
  logic [BAW-1:0]        baddr_q [ENTRIES];
  coal_dir_e             dir_q   [ENTRIES];
  logic [SLOTS-1:0]      wait_q  [ENTRIES];
  logic [SLOTS*TW-1:0]   tag_q   [ENTRIES];
  logic [ENTRIES-1:0]    match;

  int               slot;
  logic [SLOTS-1:0] slot_oh;

  always_comb begin
    slot    = int'(lk_word) * NS + int'(lk_stream);
    slot_oh = SLOTS'(1) << slot;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic                valid_r, valid_d;
    logic [BAW-1:0]      baddr_r;
    coal_dir_e           dir_r;
    logic [SLOTS-1:0]    wait_r, wait_d;
    logic [SLOTS*TW-1:0] tag_r, tag_d;
    logic                sel_alloc, sel_merge, sel_ret;

    assign sel_alloc = do_alloc  && (free_idx == IDW'(i));
    assign sel_merge = do_merge  && (hit_idx  == IDW'(i));
    assign sel_ret   = ret_valid && (ret_id   == IDW'(i));

    always_comb begin
      valid_d = valid_r;
      wait_d  = wait_r;
      tag_d   = tag_r;
      if (sel_ret) begin
        valid_d = 1'b0;
        wait_d  = '0;
      end else if (sel_alloc) begin
        valid_d = 1'b1;
        wait_d  = slot_oh;
      end else if (sel_merge) begin
        wait_d  = wait_r | slot_oh;
      end
      if (sel_alloc || sel_merge) tag_d[slot*TW +: TW] = lk_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_r <= 1'b0;
        wait_r  <= '0;
      end else begin
        valid_r <= valid_d;
        wait_r  <= wait_d;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_alloc) begin
        baddr_r <= lk_baddr;
        dir_r   <= lk_dir;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_alloc || sel_merge) tag_r <= tag_d;
    end

    // an entry retiring this cycle no longer absorbs requests
    assign match[i]   = valid_r && (baddr_r == lk_baddr) && (dir_r == lk_dir) && !sel_ret;
    assign valid_q[i] = valid_r;
    assign baddr_q[i] = baddr_r;
    assign dir_q[i]   = dir_r;
    assign wait_q[i]  = wait_r;
    assign tag_q[i]   = tag_r;
  end

  always_comb begin
    hit        = 1'b0;
    hit_idx    = '0;
    free_avail = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDW'(i);
      end
      if (!valid_q[i]) begin
        free_avail = 1'b1;
        free_idx   = IDW'(i);
      end
    end
  end

  assign slot_busy = |(wait_q[hit_idx] & slot_oh);
  assign ret_wait  = wait_q[ret_id];
  assign ret_tag   = tag_q[ret_id];

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (valid_q[i] && valid_q[j] && baddr_q[i] == baddr_q[j] && dir_q[i] == dir_q[j])
          dup = 1'b1;
  end

  AST_NO_DUP_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !dup); // R4

  AST_ALLOC_TAKES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |=> valid_q[$past(free_idx)]); // R4

  AST_ALLOC_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |-> free_avail); // R6

  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !valid_q[$past(ret_id)]); // R10

  AST_MERGE_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    do_merge |-> !slot_busy); // R7

endmodule

// File: rtl/sparse_coalescer.sv
module sparse_coalescer
  import coal_pkg::*;
#(
  parameter int NS      = 3,
  parameter int AW      = 16,
  parameter int TW      = 4,
  parameter int DW      = 32,
  parameter int WPB     = 16,
  parameter int ENTRIES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NS-1:0]                     req_valid,
  output logic [NS-1:0]                     req_ready,
  input  logic [NS*AW-1:0]                  req_addr,
  input  logic [NS*TW-1:0]                  req_tag,
  input  logic [NS-1:0]                     req_wr,
  output logic                              cmd_valid,
  input  logic                              cmd_ready,
  output logic [AW-$clog2(WPB)-1:0]         cmd_addr,
  output logic                              cmd_wr,
  output logic [$clog2(ENTRIES)-1:0]        cmd_id,
  input  logic                              mem_valid,
  input  logic [$clog2(ENTRIES)-1:0]        mem_id,
  input  logic [WPB*DW-1:0]                 mem_data,
  output logic [NS-1:0]                     rsp_valid,
  output logic [NS*WPB-1:0]                 rsp_mask,
  output logic [NS*WPB*TW-1:0]              rsp_tag,
  output logic [WPB*DW-1:0]                 rsp_data
);

  localparam int OFF_W = $clog2(WPB);
  localparam int BAW   = AW - OFF_W;
  localparam int SW    = (NS > 1) ? $clog2(NS) : 1;
  localparam int IDW   = $clog2(ENTRIES);

  logic [NS-1:0]  gnt;
  logic [SW-1:0]  gidx;
  logic           any_req, accept;
  logic [AW-1:0]  sel_addr;
  logic [TW-1:0]  sel_tag;
  coal_dir_e      sel_dir;
  logic           hit, slot_busy, free_avail;
  logic [IDW-1:0] hit_idx, free_idx;
  logic           do_merge, do_alloc;
  logic [WPB*NS-1:0]    ret_wait;
  logic [WPB*NS*TW-1:0] ret_tag;

  coal_rr_arb #(.N(NS), .IW(SW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .adv     (accept),
    .gnt     (gnt),
    .gnt_idx (gidx)
  );

  assign any_req  = |req_valid;
  assign sel_addr = req_addr[int'(gidx)*AW +: AW];
  assign sel_tag  = req_tag[int'(gidx)*TW +: TW];
  assign sel_dir  = coal_dir_e'(req_wr[gidx]);

  coal_cache #(
    .NS(NS), .BAW(BAW), .TW(TW), .WPB(WPB), .ENTRIES(ENTRIES),
    .OFF_W(OFF_W), .SW(SW), .IDW(IDW)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_baddr   (sel_addr[AW-1:OFF_W]),
    .lk_dir     (sel_dir),
    .lk_word    (sel_addr[OFF_W-1:0]),
    .lk_stream  (gidx),
    .lk_tag     (sel_tag),
    .do_merge   (do_merge),
    .do_alloc   (do_alloc),
    .ret_valid  (mem_valid),
    .ret_id     (mem_id),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .slot_busy  (slot_busy),
    .free_avail (free_avail),
    .free_idx   (free_idx),
    .ret_wait   (ret_wait),
    .ret_tag    (ret_tag)
  );

  // miss path needs a slot and the channel; hit path needs an idle word slot
  assign cmd_valid = any_req && !hit && free_avail;
  assign cmd_addr  = sel_addr[AW-1:OFF_W];
  assign cmd_wr    = sel_dir;
  assign cmd_id    = free_idx;
  assign do_alloc  = cmd_valid && cmd_ready;
  assign do_merge  = any_req && hit && !slot_busy;
  assign accept    = do_alloc || do_merge;
  assign req_ready = accept ? gnt : '0;

  // response regroup: cache slot order is word-major, outputs are stream-major
  logic [NS-1:0]         rsp_valid_d;
  logic [NS*WPB-1:0]     rsp_mask_d;
  logic [NS*WPB*TW-1:0]  rsp_tag_d;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < WPB; w++) begin
        rsp_mask_d[s*WPB + w]           = ret_wait[w*NS + s];
        rsp_tag_d[(s*WPB + w)*TW +: TW] = ret_tag[(w*NS + s)*TW +: TW];
      end
      rsp_valid_d[s] = mem_valid && (|rsp_mask_d[s*WPB +: WPB]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= '0;
    else        rsp_valid <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (mem_valid) begin
      rsp_mask <= rsp_mask_d;
      rsp_tag  <= rsp_tag_d;
      rsp_data <= mem_data;
    end
  end

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R2

  AST_RSP_FOLLOWS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> $past(mem_valid)); // R9

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R1

endmodule

// File: tb/sparse_coalescer_tb.sv
module sparse_coalescer_tb_top;

  localparam int NS = 3, AW = 16, TW = 4, DW = 32, WPB = 16, ENTRIES = 4;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NS-1:0]        req_valid, req_ready, req_wr;
  logic [NS*AW-1:0]     req_addr;
  logic [NS*TW-1:0]     req_tag;
  logic                 cmd_valid, cmd_ready, cmd_wr;
  logic [11:0]          cmd_addr;
  logic [1:0]           cmd_id, mem_id;
  logic                 mem_valid;
  logic [WPB*DW-1:0]    mem_data, rsp_data;
  logic [NS-1:0]        rsp_valid;
  logic [NS*WPB-1:0]    rsp_mask;
  logic [NS*WPB*TW-1:0] rsp_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sparse_coalescer #(.NS(NS), .AW(AW), .TW(TW), .DW(DW), .WPB(WPB), .ENTRIES(ENTRIES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_tag(req_tag), .req_wr(req_wr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_wr(cmd_wr), .cmd_id(cmd_id),
    .mem_valid(mem_valid), .mem_id(mem_id), .mem_data(mem_data),
    .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [WPB*DW-1:0] bd(input int b);
    logic [WPB*DW-1:0] d;
    for (int w = 0; w < WPB; w++) d[w*DW +: DW] = 32'h5A00_0000 | (b << 8) | w;
    return d;
  endfunction

  task automatic put(input int s, input logic v, input logic [15:0] a,
                     input logic [3:0] t, input logic w);
    req_valid[s]          = v;
    req_addr[s*AW +: AW]  = a;
    req_tag[s*TW +: TW]   = t;
    req_wr[s]             = w;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear();
    req_valid = '0;
    mem_valid = 1'b0;
  endtask

  task automatic ret(input logic [1:0] id, input int b);
    mem_valid = 1'b1;
    mem_id    = id;
    mem_data  = bd(b);
  endtask

  function automatic logic [15:0] mask_of(input int s);
    return rsp_mask[s*WPB +: WPB];
  endfunction

  function automatic logic [3:0] tag_of(input int s, input int w);
    return rsp_tag[(s*WPB + w)*TW +: TW];
  endfunction

  logic [1:0] id_a, id_a2, id_e, id_f, id_g;
  logic [1:0] id_rr [NS];

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = '0; req_addr = '0; req_tag = '0; req_wr = '0;
    cmd_ready = 1'b1; mem_valid = 1'b0; mem_id = '0; mem_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 req_ready", 64'(req_ready), 0);
    chk("R1 cmd_valid", 64'(cmd_valid), 0);
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    step();

    // first miss on burst 0x123
    put(0, 1, 16'h1234, 4'd4, 0);
    #1;
    chk("R4 miss cmd_valid", 64'(cmd_valid), 1);
    chk("R3 burst number", 64'(cmd_addr), 64'h123);
    chk("R5 read dir", 64'(cmd_wr), 0);
    chk("R2 single grant", 64'(req_ready), 1);
    id_a = cmd_id;
    step(); clear();

    // every stream, every word of the same burst
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < WPB; w++) begin
        put(s, 1, 16'h1230 | 16'(w), 4'((s*5 + w) & 15), 0);
        #1;
        if (s == 0 && w == 4) begin
          chk("R7 duplicate word stalls", 64'(req_ready), 0);
        end else begin
          chk("R4 hit merged", 64'(req_ready), 64'(1) << s);
        end
        chk("R4 hit no command", 64'(cmd_valid), 0);
        step(); clear();
      end
    end

    ret(id_a, 'h123);
    step(); clear();
    chk("R9 all streams answered", 64'(rsp_valid), 3'b111);
    for (int s = 0; s < NS; s++) begin
      chk("R9 full mask", 64'(mask_of(s)), 16'hFFFF);
      for (int w = 0; w < WPB; w++) chk("R9 R3 word tag", 64'(tag_of(s, w)), (s*5 + w) & 15);
    end
    chk("R9 data", 64'(rsp_data[63:0]), 64'(bd('h123)));
    chk("R9 data hi", 64'(rsp_data[WPB*DW-1 -: 64]), 64'(bd('h123) >> (WPB*DW - 64)));

    // freed entry: same burst again issues a command
    put(0, 1, 16'h1234, 4'd9, 0);
    #1;
    chk("R10 reissue", 64'(cmd_valid), 1);
    chk("R10 reissue addr", 64'(cmd_addr), 64'h123);
    id_a2 = cmd_id;
    step(); clear();

    // round robin, pointer sits at stream 1
    put(0, 1, 16'h2000, 4'd1, 0);
    put(1, 1, 16'h3000, 4'd2, 0);
    put(2, 1, 16'h4000, 4'd3, 0);
    for (int k = 0; k < NS; k++) begin
      int e;
      e = (k + 1) % NS;
      #1;
      chk("R2 rotation", 64'(req_ready), 64'(1) << e);
      chk("R3 rotation burst", 64'(cmd_addr), 64'h200 + 64'(e) * 64'h100);
      id_rr[e] = cmd_id;
      step();
      req_valid[e] = 1'b0;
    end
    clear();

    // table full
    put(1, 1, 16'h5000, 4'd12, 0);
    #1;
    chk("R6 full stalls", 64'(req_ready), 0);
    chk("R6 full no command", 64'(cmd_valid), 0);
    step(); clear();
    put(2, 1, 16'h2001, 4'd7, 0);
    #1;
    chk("R6 hit while full", 64'(req_ready), 3'b100);
    step(); clear();

    // retiring slot is not free in its own cycle
    ret(id_rr[1], 'h300);
    put(1, 1, 16'h5000, 4'd12, 0);
    #1;
    chk("R6 retiring not free", 64'(req_ready), 0);
    step();
    mem_valid = 1'b0;
    #1;
    chk("R9 one stream", 64'(rsp_valid), 3'b010);
    chk("R9 mask s1", 64'(mask_of(1)), 16'h0001);
    chk("R9 tag s1", 64'(tag_of(1, 0)), 2);
    chk("R9 data s1", 64'(rsp_data[31:0]), 64'(32'h5A00_0000 | ('h300 << 8)));

    cmd_ready = 1'b0;
    #1;
    chk("R8 channel busy stalls", 64'(req_ready), 0);
    chk("R8 command shown", 64'(cmd_valid), 1);
    step();
    req_valid = '0;
    put(0, 1, 16'h4002, 4'd6, 0);
    #1;
    chk("R8 hit while channel busy", 64'(req_ready), 3'b001);
    step(); clear();
    cmd_ready = 1'b1;
    put(1, 1, 16'h5000, 4'd12, 0);
    #1;
    chk("R6 accepted after free", 64'(req_ready), 3'b010);
    chk("R6 accepted addr", 64'(cmd_addr), 64'h500);
    id_e = cmd_id;
    step(); clear();

    // burst 0x200 had s0 word0 and s2 word1
    ret(id_rr[0], 'h200);
    step(); clear();
    chk("R9 two streams", 64'(rsp_valid), 3'b101);
    chk("R9 mask s0", 64'(mask_of(0)), 16'h0001);
    chk("R9 mask s2", 64'(mask_of(2)), 16'h0002);
    chk("R9 tag s0", 64'(tag_of(0, 0)), 1);
    chk("R9 tag s2", 64'(tag_of(2, 1)), 7);

    // write to a burst with a pending read
    put(0, 1, 16'h1236, 4'd3, 1);
    #1;
    chk("R5 write separate command", 64'(cmd_valid), 1);
    chk("R5 write dir", 64'(cmd_wr), 1);
    chk("R5 write addr", 64'(cmd_addr), 64'h123);
    id_f = cmd_id;
    step(); clear();

    ret(id_rr[2], 'h400);
    step(); clear();
    chk("R9 burst 0x400 streams", 64'(rsp_valid), 3'b101);
    chk("R9 mask s0 word2", 64'(mask_of(0)), 16'h0004);
    chk("R9 tag s0 word2", 64'(tag_of(0, 2)), 6);
    chk("R9 tag s2 word0", 64'(tag_of(2, 0)), 3);

    // request lands in the retirement cycle of its burst
    ret(id_a2, 'h123);
    put(2, 1, 16'h1237, 4'd11, 0);
    #1;
    chk("R11 treated as miss", 64'(cmd_valid), 1);
    chk("R11 accepted", 64'(req_ready), 3'b100);
    chk("R11 new slot", 64'(cmd_id != id_a2), 1);
    id_g = cmd_id;
    step(); clear();
    chk("R11 late request not answered", 64'(rsp_valid), 3'b001);
    chk("R10 mask", 64'(mask_of(0)), 16'h0010);
    chk("R10 tag", 64'(tag_of(0, 4)), 9);

    ret(id_e, 'h500);
    step(); clear();
    chk("R9 burst 0x500", 64'(rsp_valid), 3'b010);
    chk("R9 tag 0x500", 64'(tag_of(1, 0)), 12);
    ret(id_f, 'h123);
    step(); clear();
    chk("R5 write answered", 64'(rsp_valid), 3'b001);
    chk("R5 write mask", 64'(mask_of(0)), 16'h0040);
    chk("R5 write tag", 64'(tag_of(0, 6)), 3);
    ret(id_g, 'h123);
    step(); clear();
    chk("R11 fresh burst answered", 64'(rsp_valid), 3'b100);
    chk("R11 fresh mask", 64'(mask_of(2)), 16'h0080);
    chk("R11 fresh tag", 64'(tag_of(2, 7)), 11);
    step();
    chk("R9 no spurious response", 64'(rsp_valid), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule